// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial memory, organised in pages of 256 bytes. It watches SCL and SDA through synchronisers clocked by the system clock. It recognises bus start and stop events and answers its own device address. It pulls SDA low to acknowledge and to send zero data bits. It never drives SDA high, so the pad outside provides an open-drain line.

A write gives two word-address bytes and then one or more data bytes. The data bytes collect in a page buffer. When the host ends the write with a stop, a timed programming interval begins. During that interval the target refuses its device address, so the host learns when the interval has ended by repeating the address until it is acknowledged. At the end of the interval the buffered bytes go into the array. A read returns bytes starting at an internal address counter. It keeps going for as long as the host acknowledges each byte.

Top module: `eeprom_target`

## Requirements
- R1: After reset, SDA is released (`sda_pull` = 0) and every array byte reads 0xFF.
- R2: The device address byte is sent MSB first. Its upper seven bits are 1010 followed by `DEV_SEL[2:0]`, and its last bit selects the direction (1 = read, 0 = write). If the address does not match, the target gives no acknowledge and ignores all further bytes until the next start.
- R3: In a write, the target acknowledges both word-address bytes (high byte first, of which the low `ADDR_W` bits are used) and every data byte.
- R4: A stop that follows at least one complete data byte starts a programming interval of `PROG_CYCLES` system clocks. During the interval the device address is not acknowledged in either direction. After it, the written bytes read back.
- R5: A stop that follows the word address but no data byte starts no programming interval. The next device address is acknowledged at once.
- R6: During a write, only the low 8 bits of the address advance after each data byte. More than 256 data bytes wrap to the start of the same page and overwrite the bytes written earlier.
- R7: A current-address read returns the byte at the internal counter. The counter holds the last accessed address plus one, with the in-page wrap of R6 after a write.
- R8: In a read, a host acknowledge after a byte makes the target send the next byte. The full address advances, crossing page boundaries and wrapping from the top of the array to 0.
- R9: A host non-acknowledge ends a read. The target releases SDA, and a following start is served normally.
- R10: The target changes its SDA drive only after SCL has fallen, or on a start or stop event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The embedded properties check several rules on every cycle:
- The data line is driven only after a falling SCL edge or a bus event.
- A mismatched or busy device address is never acknowledged.
- The page row stays fixed while data bytes arrive.
- SDA is released while the host answers a read byte.
- Programming is never relaunched while busy.

Some behaviour can only be shown by bus scenarios run from the bench. These are:
- The data values returned after programming.
- The overwrite effect of a 258-byte page write.
- Where the address counter lands after a write and after a read.
- Wrapping from the top of the array.
- The length of the busy window as seen through address polling.

// File: rtl/eet_pkg.sv
package eet_pkg;
   typedef enum logic [2:0] {
      P_IDLE,
      P_DEV,
      P_AHI,
      P_ALO,
      P_WDAT,
      P_TX,
      P_TXACK
   } phase_t;

   localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eet_sync.sv
module eet_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic rise_o,
   output logic fall_o,
   output logic start_o,
   output logic stop_o
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_s, scl_p, sda_p;

   generate
      if (STAGES < 2) begin : g_bad
         $error("eet_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_s;
         sda_p  <= sda_o;
      end
   end

   assign scl_s   = scl_ff[STAGES-1];
   assign sda_o   = sda_ff[STAGES-1];
   assign rise_o  = scl_s & ~scl_p;
   assign fall_o  = ~scl_s & scl_p;
   assign start_o = scl_s & scl_p & sda_p & ~sda_o;
   assign stop_o  = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/eet_timer.sv
module eet_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (go_i)       cnt <= CW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy_o = (cnt != '0);
   assign done_o = (cnt == CW'(1));

   // R4
   prog_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> !busy_o);
endmodule

// File: rtl/eet_store.sv
module eet_store #(
   parameter int ADDR_W = 9,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic [ADDR_W-PAGE_W-1:0] row_i,
   input  logic              wr_i,
   input  logic [PAGE_W-1:0] off_i,
   input  logic [7:0]        data_i,
   input  logic              commit_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PAGE  = 1 << PAGE_W;
   localparam int ROW_W = ADDR_W - PAGE_W;

   logic [7:0]       mem  [DEPTH];
   logic [7:0]       pbuf [PAGE];
   logic [PAGE-1:0]  pvld;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (wr_i) pbuf[off_i] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
         pvld  <= '0;
         row_q <= '0;
      end else begin
         if (clr_i) begin
            pvld  <= '0;
            row_q <= row_i;
         end else if (wr_i) begin
            pvld[off_i] <= 1'b1;
         end
         if (commit_i) begin
            for (int i = 0; i < PAGE; i++)
               if (pvld[i]) mem[{row_q, PAGE_W'(i)}] <= pbuf[i];
         end
      end
   end

   assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/eeprom_target.sv
module eeprom_target #(
   parameter int         ADDR_W      = 9,
   parameter int         PAGE_W      = 8,
   parameter int         PROG_CYCLES = 1000,
   parameter logic [2:0] DEV_SEL     = 3'b000,
   parameter int         SYNC_LEN    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_pull
);
   import eet_pkg::*;

   localparam int HI_W  = ADDR_W - 8;
   localparam int ROW_W = ADDR_W - PAGE_W;

   generate
      if (ADDR_W <= 8 || ADDR_W > 16) begin : g_bad_aw
         $error("eeprom_target: ADDR_W must lie in 9..16");
      end
      if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_pw
         $error("eeprom_target: PAGE_W must lie in 1..8");
      end
      if (PROG_CYCLES < 1) begin : g_bad_pc
         $error("eeprom_target: PROG_CYCLES must be positive");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic busy, done, prog_go;
   logic st_clr, st_wr;
   logic [ROW_W-1:0]  st_row;
   logic [PAGE_W-1:0] st_off;
   logic [7:0]        st_data, rd_data;

   phase_t            phase, ph_next;
   logic [3:0]        rcnt, tcnt;
   logic              ack_slot, wrote_any;
   logic [7:0]        shreg, tx_sh;
   logic [HI_W-1:0]   addr_hi;
   logic [ADDR_W-1:0] addr_ctr, full_addr;
   logic              dev_match;

   eet_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
      .sda_o(sda_s), .rise_o(scl_rise), .fall_o(scl_fall),
      .start_o(start_evt), .stop_o(stop_evt));

   eet_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .go_i(prog_go), .busy_o(busy), .done_o(done));

   eet_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr_i(st_clr), .row_i(st_row),
      .wr_i(st_wr), .off_i(st_off), .data_i(st_data), .commit_i(done),
      .rd_addr_i(addr_ctr), .rd_data_o(rd_data));

   assign full_addr = {addr_hi, shreg};
   assign dev_match = (shreg[7:1] == {DEV_TYPE, DEV_SEL});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= P_IDLE;   ph_next <= P_IDLE;
         rcnt <= '0;        tcnt <= '0;
         ack_slot <= 1'b0;  wrote_any <= 1'b0;
         shreg <= '0;       tx_sh <= '0;
         addr_hi <= '0;     addr_ctr <= '0;
         sda_pull <= 1'b0;  prog_go <= 1'b0;
         st_clr <= 1'b0;    st_wr <= 1'b0;
         st_row <= '0;      st_off <= '0;   st_data <= '0;
      end else begin
         prog_go <= 1'b0;
         st_clr  <= 1'b0;
         st_wr   <= 1'b0;
         if (start_evt) begin
            phase <= P_DEV;  rcnt <= '0;  ack_slot <= 1'b0;
            sda_pull <= 1'b0;  wrote_any <= 1'b0;
         end else if (stop_evt) begin
            if (wrote_any) prog_go <= 1'b1;
            phase <= P_IDLE;  ack_slot <= 1'b0;
            sda_pull <= 1'b0;  wrote_any <= 1'b0;
         end else if (ack_slot) begin
            if (scl_fall) begin
               ack_slot <= 1'b0;
               rcnt     <= '0;
               phase    <= ph_next;
               if (ph_next == P_TX) begin
                  tx_sh    <= {rd_data[6:0], 1'b0};
                  sda_pull <= ~rd_data[7];
                  tcnt     <= 4'd1;
                  addr_ctr <= addr_ctr + 1'b1;
               end else begin
                  sda_pull <= 1'b0;
               end
            end
         end else begin
            case (phase)
               P_DEV, P_AHI, P_ALO, P_WDAT: begin
                  if (scl_rise && rcnt < 4'd8) begin
                     shreg <= {shreg[6:0], sda_s};
                     rcnt  <= rcnt + 1'b1;
                  end else if (scl_fall && rcnt == 4'd8) begin
                     ack_slot <= 1'b1;
                     sda_pull <= 1'b1;
                     case (phase)
                        P_DEV: begin
                           if (dev_match && !busy)
                              ph_next <= shreg[0] ? P_TX : P_AHI;
                           else begin
                              ph_next  <= P_IDLE;
                              sda_pull <= 1'b0;
                           end
                        end
                        P_AHI: begin
                           addr_hi <= shreg[HI_W-1:0];
                           ph_next <= P_ALO;
                        end
                        P_ALO: begin
                           addr_ctr <= full_addr;
                           st_clr   <= 1'b1;
                           st_row   <= full_addr[ADDR_W-1:PAGE_W];
                           ph_next  <= P_WDAT;
                        end
                        default: begin
                           st_wr     <= 1'b1;
                           st_off    <= addr_ctr[PAGE_W-1:0];
                           st_data   <= shreg;
                           addr_ctr  <= {addr_ctr[ADDR_W-1:PAGE_W],
                                         addr_ctr[PAGE_W-1:0] + 1'b1};
                           wrote_any <= 1'b1;
                           ph_next   <= P_WDAT;
                        end
                     endcase
                  end
               end
               P_TX: begin
                  if (scl_fall) begin
                     if (tcnt < 4'd8) begin
                        sda_pull <= ~tx_sh[7];
                        tx_sh    <= {tx_sh[6:0], 1'b0};
                        tcnt     <= tcnt + 1'b1;
                     end else begin
                        sda_pull <= 1'b0;
                        phase    <= P_TXACK;
                     end
                  end
               end
               P_TXACK: begin
                  if (scl_rise) begin
                     if (!sda_s) begin
                        phase    <= P_TX;
                        tcnt     <= '0;
                        tx_sh    <= rd_data;
                        addr_ctr <= addr_ctr + 1'b1;
                     end else begin
                        phase <= P_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R10
   drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> $past(scl_fall || start_evt || stop_evt));

   // R2
   addr_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_slot && phase == P_DEV && !dev_match) |-> !sda_pull);

   // R4
   busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_slot && phase == P_DEV && busy) |-> !sda_pull);

   // R6
   page_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_WDAT && $past(phase == P_WDAT))
         |-> addr_ctr[ADDR_W-1:PAGE_W] == $past(addr_ctr[ADDR_W-1:PAGE_W]));

   // R9
   host_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_TXACK) |-> !sda_pull);
endmodule

// File: tb/eeprom_target_bench.sv
module eeprom_target_bench;
   localparam int         Q    = 4;
   localparam int         PROG = 400;
   localparam logic [2:0] SEL  = 3'b101;
   localparam logic [7:0] DEVW = {4'b1010, SEL, 1'b0};
   localparam logic [7:0] DEVR = {4'b1010, SEL, 1'b1};

   // {word address, data}
   localparam logic [23:0] VEC [8] = '{
      {16'h0000, 8'h3C}, {16'h0001, 8'hA5}, {16'h0080, 8'h5E},
      {16'h00FF, 8'h96}, {16'h0042, 8'h07}, {16'h00FE, 8'hE1},
      {16'h0150, 8'h77}, {16'h01FF, 8'h4B}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_h = 1'b1;
   logic sda_pull;
   logic sda_line;
   int   n_chk = 0;
   int   n_fail = 0;

   always #2.5 clk = ~clk;
   assign sda_line = sda_h & ~sda_pull;

   eeprom_target #(.PROG_CYCLES(PROG), .DEV_SEL(SEL)) u_eeprom_target (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
      .sda_pull(sda_pull));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic put_bit(input logic b);
      sda_h = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_h = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_start();
      sda_h = 1'b1; wq(); scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq();
   endtask

   task automatic send(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv(output logic [7:0] d, input logic host_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
      put_bit(~host_ack);
   endtask

   task automatic set_addr(input logic [15:0] a, output logic ok);
      logic k0, k1, k2;
      bus_start(); send(DEVW, k0); send(a[15:8], k1); send(a[7:0], k2);
      ok = k0 & k1 & k2;
   endtask

   task automatic rd_at(input logic [15:0] a, output logic [7:0] d, output logic ok);
      logic k0, k1;
      set_addr(a, k0);
      bus_start(); send(DEVR, k1); recv(d, 1'b0); bus_stop();
      ok = k0 & k1;
   endtask

   task automatic wait_ready();
      logic ack;
      ack = 1'b0;
      for (int k = 0; k < 40 && !ack; k++) begin
         bus_start(); send(DEVW, ack); bus_stop();
         if (!ack) repeat (40) @(negedge clk);
      end
      chk(ack, "R4 ready after programming", ack, 1);
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'(i) ^ ((i >= 256) ? 8'hC3 : 8'h00);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got 0x%0h expected 0x%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic ok, ack, k;
      logic [7:0] d;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(sda_pull == 1'b0, "R1 sda released in reset", sda_pull, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(sda_pull == 1'b0, "R1 sda released after reset", sda_pull, 0);
      rd_at(16'h0010, d, ok);
      chk(ok && d == 8'hFF, "R1 erased array byte", d, 8'hFF);

      // table: byte write, then random read back (R3, R4)
      for (int v = 0; v < 8; v++) begin
         set_addr(VEC[v][23:8], ok);
         send(VEC[v][7:0], ack);
         chk(ok && ack, "R3 write acks", {ok, ack}, 3);
         bus_stop();
         wait_ready();
         rd_at(VEC[v][23:8], d, ok);
         chk(ok && d == VEC[v][7:0], "R4 byte read back", d, VEC[v][7:0]);
      end

      // R2 address mismatch, then bytes ignored until start
      bus_start(); send({4'b1010, 3'b100, 1'b0}, ack);
      chk(!ack, "R2 wrong select no ack", ack, 0);
      send(DEVW, ack);
      chk(!ack, "R2 ignored until start", ack, 0);
      bus_stop();
      bus_start(); send({4'b1011, SEL, 1'b0}, ack); bus_stop();
      chk(!ack, "R2 wrong type nibble no ack", ack, 0);

      // R5 stop without data: no busy window
      set_addr(16'h0042, ok); bus_stop();
      bus_start(); send(DEVW, ack); bus_stop();
      chk(ok && ack, "R5 no programming without data", ack, 1);

      // R4 busy window seen by polling
      set_addr(16'h0042, ok); send(8'h99, ack); bus_stop();
      bus_start(); send(DEVW, ack); bus_stop();
      chk(!ack, "R4 write poll nak while busy", ack, 0);
      bus_start(); send(DEVR, ack); bus_stop();
      chk(!ack, "R4 read poll nak while busy", ack, 0);
      repeat (PROG + 50) @(negedge clk);
      bus_start(); send(DEVW, ack); bus_stop();
      chk(ack, "R4 ack after interval", ack, 1);
      rd_at(16'h0042, d, ok);
      chk(d == 8'h99, "R4 new data committed", d, 8'h99);

      // R6 page write of 258 bytes from 0x1FE wraps inside page 1
      set_addr(16'h01FE, ok);
      k = 1'b1;
      for (int i = 0; i < 258; i++) begin send(pat(i), ack); k = k & ack; end
      chk(ok && k, "R3 ack every page byte", k, 1);
      bus_stop();
      wait_ready();
      // R7 counter after write: 0x1FF + 1 wraps in page to 0x100
      bus_start(); send(DEVR, ack); recv(d, 1'b0); bus_stop();
      chk(ack && d == pat(2), "R7 current read after page write", d, pat(2));
      rd_at(16'h01FE, d, ok);
      chk(d == pat(256), "R6 overwrite at 0x1FE", d, pat(256));
      rd_at(16'h01FF, d, ok);
      chk(d == pat(257), "R6 overwrite at 0x1FF", d, pat(257));
      rd_at(16'h017F, d, ok);
      chk(d == pat(129), "R6 mid page byte", d, pat(129));
      rd_at(16'h00FE, d, ok);
      chk(d == 8'hE1, "R6 other page untouched", d, 8'hE1);

      // R8 sequential read across a page boundary, R9 host nak ends it
      set_addr(16'h00FE, ok);
      bus_start(); send(DEVR, ack);
      recv(d, 1'b1); chk(d == 8'hE1, "R8 seq byte 0x0FE", d, 8'hE1);
      recv(d, 1'b1); chk(d == 8'h96, "R8 seq byte 0x0FF", d, 8'h96);
      recv(d, 1'b0); chk(d == pat(2), "R8 seq crosses page", d, pat(2));
      chk(sda_pull == 1'b0, "R9 released after host nak", sda_pull, 0);
      bus_stop();
      // R7 current address after read is last + 1
      bus_start(); send(DEVR, ack); recv(d, 1'b0); bus_stop();
      chk(ack && d == pat(3), "R7 current read at 0x101", d, pat(3));
      bus_start(); send(DEVR, ack); recv(d, 1'b0); bus_stop();
      chk(ack && d == pat(4), "R7 counter advances again", d, pat(4));

      // R8 wrap from top of array to 0
      set_addr(16'h01FF, ok);
      bus_start(); send(DEVR, ack);
      recv(d, 1'b1); chk(d == pat(257), "R8 top byte", d, pat(257));
      recv(d, 1'b0); chk(d == 8'h3C, "R8 wraps to 0x000", d, 8'h3C);
      bus_stop();
      // R9 a new start is served after the nak
      bus_start(); send(DEVR, ack); recv(d, 1'b0); bus_stop();
      chk(ack && d == 8'hA5, "R9 next read after nak", d, 8'hA5);

      repeat (20) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule